// File: doc/BRIEF.md
# Bidirectional Digital Pin Frame Mapper

This block services sixteen logical digital pins that are scattered over two 32-bit general-purpose I/O banks (bank A and bank B). On each service event it fetches one 32-bit control word from a double-buffered word store. In that word, bit k is the direction of logical pin k (0 = output, 1 = input) and bit k+16 is its level (1 = high). From the word it builds an output-enable value for each bank. It writes that value as a read-modify-write of the bank's current enable register, and it produces a set mask and a clear mask for each bank.

After the enable write, the block samples the bank input registers. It replaces the level bit of every input pin with the sampled value and writes the updated word back to the slot it came from. In the same cycle it drives the set and clear masks to both banks. A done pulse follows one cycle later.

A host issues a service request on every converter transaction. The block acts only when digital I/O is enabled and the low two bits of the transaction counter are zero. Each event consumes one word and moves the word pointer forward by one. The pointer wraps inside the selected buffer.

Top module: `dpm_frame_mapper`

## Requirements
- R1: After synchronous reset, `oe_wr`, `pin_wr`, `mem_wr_en` and `done` are low, and the word address `mem_rd_addr` is 0 (buffer 0, index 0).
- R2: In the idle state a service event starts only when `svc_req`, `dig_en` and `txn_cnt[1:0] == 2'b00` all hold in one cycle. Any other request produces no enable write, no pin write and no word write, and it leaves the pointer unchanged.
- R3: For an output pin (direction bit 0), the mapped bank enable bit is written 0. The mapped bit is 1 in the bank's set mask when the level bit is 1, and 1 in the clear mask when the level bit is 0. Set and clear never overlap.
- R4: For an input pin (direction bit 1), the mapped bank enable bit is written 1, and neither mask has that bit set.
- R5: Enable bits of bank positions outside the pin map are written back with the values read on `oe_a_in`/`oe_b_in`.
- R6: The written-back word keeps all sixteen direction bits and the levels of output pins. The level of each input pin k (bit k+16) is replaced by its mapped bank input bit, as sampled after the enable write.
- R7: The pin map is fixed. Logical pins 0,1,2,3 map to bank B bits 2,3,5,4. Pins 4 to 10 map to bank A bits 13,12,28,18,15,14,19. Pins 11 to 15 map to bank B bits 1,22,24,23,25.
- R8: An accepted request at clock edge E0 gives this sequence: `oe_wr` high for the cycle after E1; `pin_wr` and `mem_wr_en` high together for the cycle after E3; `done` high for the cycle after E4. Masks are zero whenever `pin_wr` is low.
- R9: The word address is `{buffer, index}`. Each event writes back at the address it read and then increments the index modulo DEPTH. An idle-cycle `frame_start` selects the buffer from `buf_sel` (0 → base 0, 1 → base DEPTH) and clears the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| svc_req | input | 1 | Converter transaction strobe |
| dig_en | input | 1 | Digital I/O enable |
| txn_cnt | input | CNT_W | Transaction counter |
| frame_start | input | 1 | Start of a buffer; reloads pointer |
| buf_sel | input | 1 | Buffer chosen at frame start |
| mem_rd_addr | output | $clog2(DEPTH)+1 | Word store address (read) |
| mem_rd_data | input | 32 | Word store read data (same cycle) |
| mem_wr_en | output | 1 | Word write-back strobe |
| mem_wr_addr | output | $clog2(DEPTH)+1 | Word write-back address |
| mem_wr_data | output | 32 | Updated word |
| oe_a_in | input | 32 | Bank A current output-enable register |
| oe_b_in | input | 32 | Bank B current output-enable register |
| oe_wr | output | 1 | Enable register write strobe |
| oe_a_out | output | 32 | New bank A enable value |
| oe_b_out | output | 32 | New bank B enable value |
| din_a | input | 32 | Bank A input register |
| din_b | input | 32 | Bank B input register |
| pin_wr | output | 1 | Set/clear mask write strobe |
| set_a | output | 32 | Bank A set mask |
| clr_a | output | 32 | Bank A clear mask |
| set_b | output | 32 | Bank B set mask |
| clr_b | output | 32 | Bank B clear mask |
| done | output | 1 | Event complete pulse |

## Verification
A single output pin is walked high across all sixteen positions to pin down the scattered map. A map entry swapped between banks or between bits would show up as a set bit in the wrong place. Random words with random prior enable values catch two faults: a design that rebuilds the enable register from zero, which would wipe unmapped bits, and one that samples inputs onto output pins, which would corrupt their levels. Requests with a nonzero counter phase or with digital I/O disabled must leave the pointer where it was. The bench also walks the index past DEPTH and switches buffers, so an off-by-one in wrap or base selection shows up as a wrong write-back address.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int WORD_W = 32;
    localparam int NPINS  = 16;
    localparam int BANK_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OE,
        ST_SAMPLE,
        ST_PUSH,
        ST_DONE
    } dpm_state_e;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        bank_e      bank;
        logic [4:0] bit_idx;
    } pin_loc_t;

    typedef struct packed {
        logic [NPINS-1:0] level;
        logic [NPINS-1:0] dir;
    } ctrl_word_t;

    typedef struct packed {
        logic [BANK_W-1:0] oe;
        logic [BANK_W-1:0] set;
        logic [BANK_W-1:0] clr;
    } bank_drive_t;

    // Fixed logical-pin to bank-bit placement.
    function automatic pin_loc_t pin_loc(input int k);
        pin_loc_t r;
        case (k)
            0:  r = '{BANK_B, 5'd2};
            1:  r = '{BANK_B, 5'd3};
            2:  r = '{BANK_B, 5'd5};
            3:  r = '{BANK_B, 5'd4};
            4:  r = '{BANK_A, 5'd13};
            5:  r = '{BANK_A, 5'd12};
            6:  r = '{BANK_A, 5'd28};
            7:  r = '{BANK_A, 5'd18};
            8:  r = '{BANK_A, 5'd15};
            9:  r = '{BANK_A, 5'd14};
            10: r = '{BANK_A, 5'd19};
            11: r = '{BANK_B, 5'd1};
            12: r = '{BANK_B, 5'd22};
            13: r = '{BANK_B, 5'd24};
            14: r = '{BANK_B, 5'd23};
            default: r = '{BANK_B, 5'd25};
        endcase
        return r;
    endfunction

    // Bank bits touched by the map.
    function automatic logic [BANK_W-1:0] mapped_bits(input bank_e b);
        logic [BANK_W-1:0] m;
        m = '0;
        for (int k = 0; k < NPINS; k++) begin
            if (pin_loc(k).bank == b) m[pin_loc(k).bit_idx] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dpm_drive_gen.sv
module dpm_drive_gen
    import dpm_pkg::*;
(
    input  ctrl_word_t        word,
    input  logic [BANK_W-1:0] oe_a_cur,
    input  logic [BANK_W-1:0] oe_b_cur,
    output bank_drive_t       drv_a,
    output bank_drive_t       drv_b
);

    always_comb begin
        drv_a     = '0;
        drv_b     = '0;
        drv_a.oe  = oe_a_cur;
        drv_b.oe  = oe_b_cur;
        for (int k = 0; k < NPINS; k++) begin
            if (pin_loc(k).bank == BANK_A) begin
                drv_a.oe[pin_loc(k).bit_idx] = word.dir[k];
                if (!word.dir[k]) begin
                    if (word.level[k]) drv_a.set[pin_loc(k).bit_idx] = 1'b1;
                    else               drv_a.clr[pin_loc(k).bit_idx] = 1'b1;
                end
            end else begin
                drv_b.oe[pin_loc(k).bit_idx] = word.dir[k];
                if (!word.dir[k]) begin
                    if (word.level[k]) drv_b.set[pin_loc(k).bit_idx] = 1'b1;
                    else               drv_b.clr[pin_loc(k).bit_idx] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dpm_in_sampler.sv
module dpm_in_sampler
    import dpm_pkg::*;
(
    input  ctrl_word_t        word,
    input  logic [BANK_W-1:0] din_a,
    input  logic [BANK_W-1:0] din_b,
    output ctrl_word_t        word_upd
);

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        localparam pin_loc_t LOC = pin_loc(k);
        logic lvl_in;
        if (LOC.bank == BANK_A) begin : g_a
            assign lvl_in = din_a[LOC.bit_idx];
        end else begin : g_b
            assign lvl_in = din_b[LOC.bit_idx];
        end
        assign word_upd.dir[k]   = word.dir[k];
        assign word_upd.level[k] = word.dir[k] ? lvl_in : word.level[k];
    end

endmodule

// File: rtl/dpm_frame_mapper.sv
module dpm_frame_mapper
    import dpm_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int CNT_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AW    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_req,
    input  logic              dig_en,
    input  logic [CNT_W-1:0]  txn_cnt,
    input  logic              frame_start,
    input  logic              buf_sel,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic [BANK_W-1:0] oe_a_in,
    input  logic [BANK_W-1:0] oe_b_in,
    output logic              oe_wr,
    output logic [BANK_W-1:0] oe_a_out,
    output logic [BANK_W-1:0] oe_b_out,
    input  logic [BANK_W-1:0] din_a,
    input  logic [BANK_W-1:0] din_b,
    output logic              pin_wr,
    output logic [BANK_W-1:0] set_a,
    output logic [BANK_W-1:0] clr_a,
    output logic [BANK_W-1:0] set_b,
    output logic [BANK_W-1:0] clr_b,
    output logic              done
);

    localparam logic [BANK_W-1:0] MAP_A = mapped_bits(BANK_A);
    localparam logic [BANK_W-1:0] MAP_B = mapped_bits(BANK_B);

    dpm_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             buf_q;
    ctrl_word_t       word_q;
    ctrl_word_t       word_smp;
    bank_drive_t      drv_a;
    bank_drive_t      drv_b;
    logic             event_hit;

    assign event_hit = svc_req && dig_en && (txn_cnt[1:0] == 2'b00);

    dpm_drive_gen u_drive (
        .word     (word_q),
        .oe_a_cur (oe_a_in),
        .oe_b_cur (oe_b_in),
        .drv_a    (drv_a),
        .drv_b    (drv_b)
    );

    dpm_in_sampler u_sample (
        .word     (word_q),
        .din_a    (din_a),
        .din_b    (din_b),
        .word_upd (word_smp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            buf_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (frame_start) begin
                        buf_q <= buf_sel;
                        idx_q <= '0;
                    end else if (event_hit) begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    word_q  <= ctrl_word_t'(mem_rd_data);
                    state_q <= ST_OE;
                end
                ST_OE:     state_q <= ST_SAMPLE;
                ST_SAMPLE: begin
                    word_q  <= word_smp;
                    state_q <= ST_PUSH;
                end
                ST_PUSH: begin
                    idx_q   <= idx_q + 1'b1;
                    state_q <= ST_DONE;
                end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign oe_wr       = (state_q == ST_OE);
    assign pin_wr      = (state_q == ST_PUSH);
    assign mem_wr_en   = pin_wr;
    assign done        = (state_q == ST_DONE);
    assign mem_rd_addr = {buf_q, idx_q};
    assign mem_wr_addr = {buf_q, idx_q};
    assign mem_wr_data = word_q;
    assign oe_a_out    = drv_a.oe;
    assign oe_b_out    = drv_b.oe;
    assign set_a       = pin_wr ? drv_a.set : '0;
    assign clr_a       = pin_wr ? drv_a.clr : '0;
    assign set_b       = pin_wr ? drv_b.set : '0;
    assign clr_b       = pin_wr ? drv_b.clr : '0;

    // R2: a disabled request in idle keeps the block idle
    a_r2_gated_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && svc_req && !dig_en && !frame_start) |=> (state_q == ST_IDLE));

    // R3: set and clear masks are disjoint in both banks
    a_r3_set_clr_disjoint: assert property (@(posedge clk) disable iff (rst)
        pin_wr |-> (((set_a & clr_a) == '0) && ((set_b & clr_b) == '0)));

    // R5: unmapped enable bits pass through the read-modify-write
    a_r5_unmapped_oe: assert property (@(posedge clk) disable iff (rst)
        oe_wr |-> ((((oe_a_out ^ oe_a_in) & ~MAP_A) == '0) &&
                   (((oe_b_out ^ oe_b_in) & ~MAP_B) == '0)));

    // R6: direction half of the written word equals the fetched one
    a_r6_dir_kept: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_data[NPINS-1:0] == $past(mem_rd_data[NPINS-1:0], 3)));

    // R8: enable write precedes the mask write by two cycles
    a_r8_oe_first: assert property (@(posedge clk) disable iff (rst)
        pin_wr |-> $past(oe_wr, 2));

    // R8: done follows the word write-back
    a_r8_done_after_wr: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> done);

endmodule

// File: tb/dpm_frame_mapper_tb.sv
module dpm_frame_mapper_tb_top;

    localparam int DEPTH = 8;
    localparam int CNT_W = 4;
    localparam int AW    = $clog2(DEPTH) + 1;

    logic              clk = 1'b0;
    logic              rst;
    logic              svc_req, dig_en, frame_start, buf_sel;
    logic [CNT_W-1:0]  txn_cnt;
    logic [AW-1:0]     mem_rd_addr, mem_wr_addr;
    logic [31:0]       mem_rd_data, mem_wr_data;
    logic              mem_wr_en, oe_wr, pin_wr, done;
    logic [31:0]       oe_a_in, oe_b_in, oe_a_out, oe_b_out;
    logic [31:0]       din_a, din_b, set_a, clr_a, set_b, clr_b;

    logic [31:0] mem [2*DEPTH];
    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int ptr_idx  = 0;
    int ptr_buf  = 0;

    always #5 clk = ~clk;

    assign mem_rd_data = mem[mem_rd_addr];

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    dpm_frame_mapper #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .svc_req(svc_req), .dig_en(dig_en), .txn_cnt(txn_cnt),
        .frame_start(frame_start), .buf_sel(buf_sel),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .oe_a_in(oe_a_in), .oe_b_in(oe_b_in), .oe_wr(oe_wr),
        .oe_a_out(oe_a_out), .oe_b_out(oe_b_out),
        .din_a(din_a), .din_b(din_b), .pin_wr(pin_wr),
        .set_a(set_a), .clr_a(clr_a), .set_b(set_b), .clr_b(clr_b), .done(done)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: act=%0d cycles exp<50000", cyc);
            summary();
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Pin placement per the R7 table: bank 0 = A, 1 = B
    function automatic void bmap(input int k, output int bank, output int bitn);
        int b_bits[16] = '{2, 3, 5, 4, 13, 12, 28, 18, 15, 14, 19, 1, 22, 24, 23, 25};
        bank = (k >= 4 && k <= 10) ? 0 : 1;
        bitn = b_bits[k];
    endfunction

    task automatic run_event(input logic [31:0] w, input logic [31:0] da, input logic [31:0] db,
                             input logic [CNT_W-1:0] phase);
        logic [31:0] e_oea, e_oeb, e_sa, e_ca, e_sb, e_cb, e_w;
        logic        c_oe_wr, c_pw2, c_pw, c_mw, c_done;
        logic [31:0] c_oea, c_oeb, c_sa, c_ca, c_sb, c_cb, c_wd;
        logic [AW-1:0] c_wa;
        int bank, bitn;
        logic [31:0] din;
        e_oea = oe_a_in; e_oeb = oe_b_in;
        e_sa = 0; e_ca = 0; e_sb = 0; e_cb = 0; e_w = w;
        for (int k = 0; k < 16; k++) begin
            bmap(k, bank, bitn);
            din = (bank == 0) ? da : db;
            if (w[k]) begin
                if (bank == 0) e_oea[bitn] = 1'b1; else e_oeb[bitn] = 1'b1;
                e_w[k+16] = din[bitn];
            end else begin
                if (bank == 0) begin
                    e_oea[bitn] = 1'b0;
                    if (w[k+16]) e_sa[bitn] = 1'b1; else e_ca[bitn] = 1'b1;
                end else begin
                    e_oeb[bitn] = 1'b0;
                    if (w[k+16]) e_sb[bitn] = 1'b1; else e_cb[bitn] = 1'b1;
                end
            end
        end
        mem[ptr_buf*DEPTH + ptr_idx] = w;
        din_a = da; din_b = db;
        dig_en = 1'b1; txn_cnt = phase; svc_req = 1'b1;
        @(negedge clk);
        svc_req = 1'b0;
        @(negedge clk);
        c_oe_wr = oe_wr; c_oea = oe_a_out; c_oeb = oe_b_out;
        @(negedge clk);
        c_pw2 = pin_wr;
        @(negedge clk);
        c_pw = pin_wr; c_mw = mem_wr_en; c_wa = mem_wr_addr; c_wd = mem_wr_data;
        c_sa = set_a; c_ca = clr_a; c_sb = set_b; c_cb = clr_b;
        @(negedge clk);
        c_done = done;
        chk("R8 oe strobe then pin strobe", {c_oe_wr, c_pw2, c_pw, c_mw, c_done}, 5'b10111);
        chk("R3/R4/R5 enable values", {c_oea, c_oeb}, {e_oea, e_oeb});
        chk("R3/R4/R7 set-clear masks", {c_sa, c_ca, c_sb, c_cb}, {e_sa, e_ca, e_sb, e_cb});
        chk("R6 written word", c_wd, e_w);
        chk("R9 write address", c_wa, (ptr_buf*DEPTH + ptr_idx));
        oe_a_in = c_oea; oe_b_in = c_oeb;
        ptr_idx = (ptr_idx + 1) % DEPTH;
        @(negedge clk);
    endtask

    task automatic no_event(input logic en, input logic [CNT_W-1:0] phase);
        logic seen;
        seen = 1'b0;
        dig_en = en; txn_cnt = phase; svc_req = 1'b1;
        @(negedge clk);
        svc_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            seen |= oe_wr | pin_wr | mem_wr_en | done;
            @(negedge clk);
        end
        chk("R2 gated request ignored", {seen, mem_rd_addr}, {1'b0, AW'(ptr_buf*DEPTH + ptr_idx)});
    endtask

    task automatic start_frame(input logic b);
        frame_start = 1'b1; buf_sel = b;
        @(negedge clk);
        frame_start = 1'b0;
        ptr_buf = b; ptr_idx = 0;
        @(negedge clk);
        chk("R9 frame start base", mem_rd_addr, AW'(b * DEPTH));
    endtask

    initial begin
        for (int i = 0; i < 2*DEPTH; i++) mem[i] = '0;
        rst = 1'b1; svc_req = 0; dig_en = 0; txn_cnt = 0; frame_start = 0; buf_sel = 0;
        oe_a_in = 32'hFFFF_FFFF; oe_b_in = 32'hFFFF_FFFF; din_a = 0; din_b = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state", {oe_wr, pin_wr, mem_wr_en, done, mem_rd_addr}, '0);

        run_event(32'hFFFF_0000, 32'h0, 32'h0, 4'd0);           // R3 all high
        run_event(32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0); // R3 all low
        run_event(32'h0000_FFFF, 32'h5555_AAAA, 32'hA5A5_5A5A, 4'd0); // R4 R6 all inputs
        run_event(32'hA5A5_00FF, 32'hFFFF_FFFF, 32'h0, 4'd4);   // R6 mixed
        for (int k = 0; k < 16; k++) run_event(32'h0001_0000 << k, 32'h0, 32'h0, 4'd8); // R7 walk
        for (int k = 0; k < 16; k++) run_event(32'hFFFF_FFFF ^ (32'h1 << k), 32'hFFFF_FFFF, 32'h0, 4'd0); // R4 walk
        no_event(1'b0, 4'd0);                                   // R2 disabled
        no_event(1'b1, 4'd1);                                   // R2 phase 1
        no_event(1'b1, 4'd2);
        no_event(1'b1, 4'd3);
        run_event(32'h1234_5678, 32'h0F0F_F0F0, 32'hCCCC_3333, 4'd12);
        start_frame(1'b1);
        for (int i = 0; i < 10; i++) begin                      // R5 R9 wrap in buffer 1
            oe_a_in = $urandom; oe_b_in = $urandom;
            run_event($urandom, $urandom, $urandom, 4'd0);
        end
        start_frame(1'b0);
        for (int i = 0; i < 30; i++) begin
            oe_a_in = $urandom; oe_b_in = $urandom;
            run_event($urandom, $urandom, $urandom, CNT_W'({$urandom % 4, 2'b00}));
        end
        summary();
    end

endmodule